// File: doc/BRIEF.md
# Byte-Command GPIO Bank Controller

This block sits on the device side of a command link. It takes host command bytes from a byte-wide valid/ready input stream and controls sixteen general-purpose pins, grouped as a low bank and a high bank of eight pins each. Each bank holds an output latch and a direction register. Pin n belongs to bank n>>3, at bit position n&7.

Two command kinds are decoded. A write command is three bytes long. A read command is one byte long. A read command samples the synchronised pin levels of the addressed bank. It returns a three-byte reply on a byte-wide valid/ready output stream: two fixed status bytes, then the sampled data byte. Any other opcode byte is discarded, and the parser stays idle.

The controller is built around one state machine with six states:
- ST_IDLE waits for an opcode.
- ST_SET_VAL waits for the output-value byte.
- ST_SET_DIR waits for the direction byte.
- ST_RSP_S0, ST_RSP_S1 and ST_RSP_DAT each present one reply byte.

The transitions are:
- From ST_IDLE, a write opcode moves to ST_SET_VAL and a read opcode moves to ST_RSP_S0. An unknown opcode keeps the machine in ST_IDLE.
- ST_SET_VAL moves to ST_SET_DIR when its byte is accepted.
- ST_SET_DIR returns to ST_IDLE when its byte is accepted.
- ST_RSP_S0 moves to ST_RSP_S1, ST_RSP_S1 moves to ST_RSP_DAT, and ST_RSP_DAT returns to ST_IDLE. Each of these steps happens on a reply handshake.

Top module: `gpio_cmd_engine`

## Requirements
- R1: While reset is applied and after it is released:
  - every direction bit is 0 (`pad_oe` = 0) and every output latch is 0 (`pad_o` = 0);
  - `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: A write command is the opcode 8'h80 (low bank) or 8'h82 (high bank), followed by the output-value byte and then the direction byte. The addressed bank's `pad_o` and `pad_oe` bits take the two argument bytes in the cycle after the direction byte is accepted.
- R3: A write command leaves the other bank's latch and direction unchanged. No latch or direction bit changes in a cycle without an accepted command byte.
- R4: Pin n is controlled by bit n&7 of the bank n>>3 registers. `pad_oe[n]` = 1 means the pin is driven with `pad_o[n]`; `pad_oe[n]` = 0 means the pin is an input (tri-stated).
- R5: A read command is the single byte 8'h81 (low bank) or 8'h83 (high bank). It produces exactly three reply bytes, in this order: 8'h32, then 8'h60, then the data byte.
- R6: The reply data byte holds the synchronised levels of the addressed bank's `pin_in` bits, with bit k equal to pin (bank*8 + k).
- R7: An opcode byte other than 8'h80 to 8'h83 is dropped:
  - no reply is produced;
  - no register changes;
  - the next byte is decoded as a new opcode.
- R8: While a reply is pending, `cmd_ready` is 0. A reply byte held with `rsp_ready` = 0 keeps `rsp_valid` high and `rsp_data` unchanged.
- R9: `pin_in` passes through a two-flop synchroniser. A read accepted three or more cycles after a pin change returns the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_data | input | 8 | Command byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte accepted when high with cmd_valid |
| rsp_data | output | 8 | Reply byte |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_ready | input | 1 | Consumer accepts the reply byte |
| pin_in | input | 16 | Pin levels, asynchronous |
| pad_o | output | 16 | Output latch values |
| pad_oe | output | 16 | Drive enables (1 = output) |

## Verification
The assertions take for granted that both streams follow valid/ready rules: a consumer may hold `rsp_ready` low for any number of cycles, and the host only changes `cmd_data` after its byte has been taken. The bench meets this in two ways. Its driver holds each byte until `cmd_ready` is seen. Its reply consumer toggles `rsp_ready` in an irregular pattern, so the hold-and-stall behaviour is exercised throughout. Pin levels are changed only between commands, with enough idle cycles for the synchroniser to settle before a read.

// File: rtl/gce_pkg.sv
package gce_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_VAL,
        ST_SET_DIR,
        ST_RSP_S0,
        ST_RSP_S1,
        ST_RSP_DAT
    } gce_state_e;

    // Upper six bits common to all four valid opcodes; bit 1 picks the bank, bit 0 picks read.
    localparam logic [7:0] OPC_BASE = 8'h80;
    localparam logic [7:0] OPC_MASK = 8'hFC;
    localparam int         NUM_BANKS = 2;
endpackage

// File: rtl/gce_sync.sv
module gce_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/gce_bank_regs.sv
module gce_bank_regs #(
    parameter int NB = 2,
    parameter int BW = 8,
    localparam int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_bank,
    input  logic [BW-1:0]    wr_val,
    input  logic [BW-1:0]    wr_dir,
    output logic [NB*BW-1:0] lat_o,
    output logic [NB*BW-1:0] dir_o
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_o[b*BW +: BW] <= '0;
                dir_o[b*BW +: BW] <= '0;
            end else if (wr_en && (wr_bank == IDXW'(b))) begin
                // latch and direction change in the same cycle
                lat_o[b*BW +: BW] <= wr_val;
                dir_o[b*BW +: BW] <= wr_dir;
            end
        end
    end
endmodule

// File: rtl/gce_ctrl.sv
module gce_ctrl
    import gce_pkg::*;
#(
    parameter int          BW  = 8,
    parameter logic [7:0]  ST0 = 8'h32,
    parameter logic [7:0]  ST1 = 8'h60,
    localparam int         PW  = NUM_BANKS * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    cmd_data,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    output logic [7:0]    rsp_data,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    input  logic [PW-1:0] pins_sync,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [BW-1:0] wr_val,
    output logic [BW-1:0] wr_dir
);
    gce_state_e state, state_nx;
    logic          bank_q;
    logic [BW-1:0] val_q;
    logic [BW-1:0] snap_q;
    logic          take;
    logic          give;
    logic          opc_ok;

    assign take   = cmd_valid && cmd_ready;
    assign give   = rsp_valid && rsp_ready;
    assign opc_ok = (cmd_data & OPC_MASK) == OPC_BASE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (take && opc_ok) state_nx = cmd_data[0] ? ST_RSP_S0 : ST_SET_VAL;
            ST_SET_VAL: if (take) state_nx = ST_SET_DIR;
            ST_SET_DIR: if (take) state_nx = ST_IDLE;
            ST_RSP_S0:  if (give) state_nx = ST_RSP_S1;
            ST_RSP_S1:  if (give) state_nx = ST_RSP_DAT;
            ST_RSP_DAT: if (give) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // argument and snapshot capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            val_q  <= '0;
            snap_q <= '0;
        end else begin
            if (state == ST_IDLE && take && opc_ok) begin
                bank_q <= cmd_data[1];
                snap_q <= pins_sync[(cmd_data[1] ? BW : 0) +: BW];
            end
            if (state == ST_SET_VAL && take) val_q <= cmd_data;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
        unique case (state)
            ST_IDLE, ST_SET_VAL, ST_SET_DIR: cmd_ready = 1'b1;
            ST_RSP_S0:  begin rsp_valid = 1'b1; rsp_data = ST0; end
            ST_RSP_S1:  begin rsp_valid = 1'b1; rsp_data = ST1; end
            ST_RSP_DAT: begin rsp_valid = 1'b1; rsp_data = 8'(snap_q); end
            default: ;
        endcase
    end

    assign wr_en   = (state == ST_SET_DIR) && take;
    assign wr_bank = bank_q;
    assign wr_val  = val_q;
    assign wr_dir  = cmd_data[BW-1:0];
endmodule

// File: rtl/gpio_cmd_engine.sv
module gpio_cmd_engine
    import gce_pkg::*;
#(
    parameter int         BANK_W = 8,
    parameter logic [7:0] STAT0  = 8'h32,
    parameter logic [7:0] STAT1  = 8'h60,
    localparam int        PINS   = NUM_BANKS * BANK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      cmd_data,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    output logic [7:0]      rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pad_o,
    output logic [PINS-1:0] pad_oe
);
    logic [PINS-1:0]   pins_sync;
    logic              wr_en;
    logic              wr_bank;
    logic [BANK_W-1:0] wr_val;
    logic [BANK_W-1:0] wr_dir;

    gce_sync #(.WIDTH(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pins_sync)
    );

    gce_ctrl #(.BW(BANK_W), .ST0(STAT0), .ST1(STAT1)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_data  (cmd_data),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .pins_sync (pins_sync),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_val    (wr_val),
        .wr_dir    (wr_dir)
    );

    gce_bank_regs #(.NB(NUM_BANKS), .BW(BANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_val  (wr_val),
        .wr_dir  (wr_dir),
        .lat_o   (pad_o),
        .dir_o   (pad_oe)
    );
endmodule

// File: rtl/gce_checker.sv
module gce_checker #(
    parameter int         PINS  = 16,
    parameter logic [7:0] STAT0 = 8'h32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [7:0]      rsp_data,
    input logic [PINS-1:0] pad_o,
    input logic [PINS-1:0] pad_oe
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R8

    AST_NO_CMD_DURING_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R8

    AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(pad_o) && $stable(pad_oe)); // R3

    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> rsp_data == STAT0); // R5

    AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(cmd_valid && cmd_ready)); // R5

    always_comb begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!rsp_valid); // R1
        end
    end
endmodule

bind gpio_cmd_engine gce_checker #(.PINS(PINS), .STAT0(STAT0)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_cmd_engine_bench.sv
`timescale 1ns/1ps
module gpio_cmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pad_o;
    logic [15:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_cmd_engine u_gpio_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .pin_in(pin_in), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_data  = b;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic do_set(input bit bank, input logic [7:0] val, input logic [7:0] dir);
        send_byte(bank ? 8'h82 : 8'h80);
        send_byte(val);
        send_byte(dir);
    endtask

    task automatic do_get(input bit bank, input logic [7:0] exp_data, input string tag);
        exp_q.push_back(8'h32);    tag_q.push_back("R5");
        exp_q.push_back(8'h60);    tag_q.push_back("R5");
        exp_q.push_back(exp_data); tag_q.push_back(tag);
        send_byte(bank ? 8'h83 : 8'h81);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    // irregular reply back-pressure
    initial begin
        forever begin
            @(posedge clk); #1;
            rsp_ready = ($urandom % 4) != 0;
        end
    end

    // scoreboard monitor
    logic       held = 1'b0;
    logic [7:0] held_data = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) check("R8 cmd_ready low during reply", {31'd0, cmd_ready}, 32'd0);
            if (held) check("R8 reply byte held", {24'd0, rsp_data}, {24'd0, held_data});
            held      = rsp_valid && !rsp_ready;
            held_data = rsp_data;
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected reply byte", {24'd0, rsp_data}, 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {24'd0, rsp_data}, {24'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pad_oe in reset", {16'd0, pad_oe}, 32'd0);
        check("R1 pad_o in reset", {16'd0, pad_o}, 32'd0);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R1 pad_oe after reset", {16'd0, pad_oe}, 32'd0);

        // R2 R4: low bank write
        do_set(1'b0, 8'hA5, 8'h0F);
        check("R2 low latch", {16'd0, pad_o}, 32'h0000_00A5);
        check("R4 low dir bits 0..7", {16'd0, pad_oe}, 32'h0000_000F);

        // R3: high bank write leaves low bank alone
        do_set(1'b1, 8'h3C, 8'hF0);
        check("R3 both banks latch", {16'd0, pad_o}, 32'h0000_3CA5);
        check("R3 both banks dir", {16'd0, pad_oe}, 32'h0000_F00F);
        do_set(1'b0, 8'h00, 8'hFF);
        check("R3 high bank kept latch", {16'd0, pad_o}, 32'h0000_3C00);
        check("R4 pin 8..15 dir by bank 1", {16'd0, pad_oe}, 32'h0000_F0FF);

        // R5 R6: reads of both banks
        pin_in = 16'h5AC3;
        repeat (4) @(posedge clk);
        do_get(1'b0, 8'hC3, "R6 low bank data");
        drain();
        do_get(1'b1, 8'h5A, "R6 high bank data");
        drain();

        // R7: unknown opcodes are dropped
        send_byte(8'h84);
        send_byte(8'h7F);
        send_byte(8'hFF);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 no reply", {31'd0, rsp_valid}, 32'd0);
        check("R7 latch unchanged", {16'd0, pad_o}, 32'h0000_3C00);
        check("R7 dir unchanged", {16'd0, pad_oe}, 32'h0000_F0FF);
        do_get(1'b1, 8'h5A, "R7 decoder back in idle");
        drain();

        // R9: pin change then read after synchroniser delay
        pin_in = 16'h81FE;
        repeat (3) @(posedge clk);
        do_get(1'b0, 8'hFE, "R9 new low level");
        do_get(1'b1, 8'h81, "R9 new high level");
        drain();

        // R2: write after reads, with every output enabled
        do_set(1'b1, 8'hFF, 8'hFF);
        check("R2 high latch all ones", {16'd0, pad_o}, 32'h0000_FF00);
        check("R2 high dir all ones", {16'd0, pad_oe}, 32'h0000_FFFF);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule